// File: doc/BRIEF.md
# DDR SDRAM Command Spacing Monitor

This block sits passively on the command bus of a four-bank DDR SDRAM. On every rising clock edge it turns chip select, RAS, CAS and WE into a command. It keeps a model of which banks hold an open row. It also measures how many clocks have passed since the last write, read, burst stop and mode-register set, both bus-wide and per bank. A command that arrives before its minimum spacing has elapsed is flagged. So is a command that does not fit the current bank state.

Burst length and CAS latency are configuration inputs, because most spacing limits are derived from them. Half-clock limits are rounded up to whole clocks. Results are registered and appear one clock after the command is sampled:
- a strobe and the decoded command,
- one flag bit per rule,
- a code naming the highest-priority rule that fired.

A flagged command is still applied to the bank model, so checking continues from the state the memory would actually be in.

Top module: `ddr_cmd_checker`

## Requirements
- R1: While `cs_ni` is high, no command is decoded: the cycle reports `cmd_vld_o`=0, `cmd_o`=0 and no violation, and bank state and all timers are left unchanged.
- R2: Commands are decoded from {ras,cas,we} with chip select low, as follows:
  - 011 ACT=1
  - 101 RD=2
  - 100 WR=3
  - 010 PRE=4
  - 001 REF=5
  - 000 MRS=6
  - 110 BST=7
  - 111 NOP=0

  One clock after the sampling edge, `cmd_o` carries the code and `cmd_vld_o` is 1 for every command except NOP.
- R3: PRE with `a10_i`=1 closes every bank; PRE with `a10_i`=0 closes only the addressed bank.
- R4: RD or WR with `a10_i`=1 leaves the addressed bank closed afterwards (auto-precharge); with `a10_i`=0 the bank stays open.
- R5: A PRE that closes an open bank fewer than 3+BL/2 clocks after a WR to that bank sets flag bit 1. An all-bank PRE checks every open bank.
- R6: A PRE that closes an open bank fewer than BL/2 clocks after a RD to that bank sets flag bit 2.
- R7: A RD fewer than 2+BL/2 clocks after any WR sets flag bit 3.
- R8: A WR sets flag bit 4 if it comes too soon after any RD. The minimum is 2+BL/2 clocks when `cl_half_i`=0 (CL 2) and 3+BL/2 clocks when `cl_half_i`=1 (CL 2.5).
- R9: A WR sets flag bit 5 if it comes too soon after a BST. The minimum is 2 clocks when `cl_half_i`=0 and 3 clocks when `cl_half_i`=1.
- R10: An ACT or MRS fewer than 2 clocks after an MRS sets flag bit 6.
- R11: A RD or WR to a closed bank, or an ACT to an open bank, sets flag bit 0 (illegal bank state).
- R12: Flags appear only in the cycle that reports the offending command. `viol_code_o` is 1 plus the index of the lowest set flag bit, or 0 when no flag is set. The offending command is still applied to the bank model and the timers.
- R13: `bl_sel_i` encodes the burst length as follows: 00 is BL2, 01 is BL4, 10 is BL8, and 11 is treated as BL8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | BA_W (2) | Bank address, bit 1 = BA1, bit 0 = BA0 |
| a10_i | input | 1 | All-bank / auto-precharge select |
| bl_sel_i | input | 2 | Burst length select |
| cl_half_i | input | 1 | 1 selects CAS latency 2.5, 0 selects 2 |
| cmd_vld_o | output | 1 | Decoded non-NOP command strobe |
| cmd_o | output | 3 | Decoded command code |
| viol_o | output | 7 | Per-rule violation flags |
| viol_code_o | output | 3 | Highest-priority violation code |

## Verification
The bench builds the block with its defaults: four banks and 4-bit saturating timers. Every bank is therefore reachable, and the largest limit (7 clocks, read-to-write at BL8 and CL 2.5) stays below the saturation value of 15. Each rule is driven both one clock short of its limit and exactly at it. This is done under BL2, BL4, BL8 and the reserved encoding, and under both CAS latencies. All-bank precharge, auto-precharge and deselected cycles are exercised too, so that the bank model is probed after each of them.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6,
    CMD_BST = 3'd7
  } cmd_e;

  // rule index = flag bit; lower index wins the code
  localparam int RULE_STATE  = 0;
  localparam int RULE_WR2PRE = 1;
  localparam int RULE_RD2PRE = 2;
  localparam int RULE_WR2RD  = 3;
  localparam int RULE_RD2WR  = 4;
  localparam int RULE_BST2WR = 5;
  localparam int RULE_MRS    = 6;
  localparam int NUM_RULES   = 7;
  localparam int CODE_W      = $clog2(NUM_RULES + 1);

  localparam int MRS_GAP = 2;

endpackage

// File: rtl/ddr_gap_timer.sv
module ddr_gap_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  // clocks since last start; saturates so idle history never flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_o <= CntMax;
    else if (start_i)        cnt_o <= CNT_W'(1);
    else if (cnt_o != CntMax) cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_chk_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        3'b110:  cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_state.sv
module ddr_bank_state
  import ddr_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 4,
  parameter int BA_W      = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  cmd_e                            cmd_i,
  input  logic [BA_W-1:0]                 bank_i,
  input  logic                            a10_i,
  output logic [NUM_BANKS-1:0]            open_o,
  output logic [NUM_BANKS-1:0][CNT_W-1:0] since_wr_o,
  output logic [NUM_BANKS-1:0][CNT_W-1:0] since_rd_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_i == BA_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[b] <= 1'b0;
      end else if (cmd_i == CMD_ACT && hit) begin
        open_o[b] <= 1'b1;
      end else if (cmd_i == CMD_PRE && (a10_i || hit)) begin
        open_o[b] <= 1'b0;
      end else if ((cmd_i == CMD_RD || cmd_i == CMD_WR) && hit && a10_i) begin
        open_o[b] <= 1'b0;  // auto-precharge
      end
    end

    ddr_gap_timer #(.CNT_W(CNT_W)) u_wr_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(cmd_i == CMD_WR && hit),
      .cnt_o  (since_wr_o[b])
    );

    ddr_gap_timer #(.CNT_W(CNT_W)) u_rd_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(cmd_i == CMD_RD && hit),
      .cnt_o  (since_rd_o[b])
    );
  end
endmodule

// File: rtl/ddr_rule_eval.sv
module ddr_rule_eval
  import ddr_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 4,
  parameter int BA_W      = 2
) (
  input  cmd_e                            cmd_i,
  input  logic [BA_W-1:0]                 bank_i,
  input  logic                            a10_i,
  input  logic [1:0]                      bl_sel_i,
  input  logic                            cl_half_i,
  input  logic [NUM_BANKS-1:0]            open_i,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0] bank_wr_i,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0] bank_rd_i,
  input  logic [CNT_W-1:0]                since_wr_i,
  input  logic [CNT_W-1:0]                since_rd_i,
  input  logic [CNT_W-1:0]                since_bst_i,
  input  logic [CNT_W-1:0]                since_mrs_i,
  output logic [NUM_RULES-1:0]            viol_o
);
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] lim_wr2pre, lim_rd2pre, lim_wr2rd, lim_rd2wr, lim_bst2wr;
  logic [NUM_BANKS-1:0] pre_tgt, wr_short, rd_short;
  logic bank_open;

  always_comb begin
    unique case (bl_sel_i)
      2'b00:   half = CNT_W'(1);
      2'b01:   half = CNT_W'(2);
      default: half = CNT_W'(4);
    endcase
  end

  // CL 2.5 half-clock terms rounded up
  assign lim_wr2pre = CNT_W'(3) + half;
  assign lim_rd2pre = half;
  assign lim_wr2rd  = CNT_W'(2) + half;
  assign lim_rd2wr  = CNT_W'(2) + half + CNT_W'(cl_half_i);
  assign lim_bst2wr = CNT_W'(2) + CNT_W'(cl_half_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pre
    assign pre_tgt[b]  = open_i[b] && (a10_i || bank_i == BA_W'(b));
    assign wr_short[b] = bank_wr_i[b] < lim_wr2pre;
    assign rd_short[b] = bank_rd_i[b] < lim_rd2pre;
  end

  assign bank_open = open_i[bank_i];

  always_comb begin
    viol_o = '0;
    viol_o[RULE_STATE]  = ((cmd_i == CMD_RD || cmd_i == CMD_WR) && !bank_open) ||
                          (cmd_i == CMD_ACT && bank_open);
    viol_o[RULE_WR2PRE] = (cmd_i == CMD_PRE) && |(pre_tgt & wr_short);
    viol_o[RULE_RD2PRE] = (cmd_i == CMD_PRE) && |(pre_tgt & rd_short);
    viol_o[RULE_WR2RD]  = (cmd_i == CMD_RD) && (since_wr_i < lim_wr2rd);
    viol_o[RULE_RD2WR]  = (cmd_i == CMD_WR) && (since_rd_i < lim_rd2wr);
    viol_o[RULE_BST2WR] = (cmd_i == CMD_WR) && (since_bst_i < lim_bst2wr);
    viol_o[RULE_MRS]    = (cmd_i == CMD_ACT || cmd_i == CMD_MRS) &&
                          (since_mrs_i < CNT_W'(MRS_GAP));
  end
endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
  import ddr_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 a10_i,
  input  logic [1:0]           bl_sel_i,
  input  logic                 cl_half_i,
  output logic                 cmd_vld_o,
  output logic [2:0]           cmd_o,
  output logic [NUM_RULES-1:0] viol_o,
  output logic [CODE_W-1:0]    viol_code_o
);
  cmd_e cmd;
  logic [BA_W-1:0] bank;
  logic [NUM_BANKS-1:0] open;
  logic [NUM_BANKS-1:0][CNT_W-1:0] bank_wr, bank_rd;
  logic [CNT_W-1:0] since_wr, since_rd, since_bst, since_mrs;
  logic [NUM_RULES-1:0] viol;
  logic [CODE_W-1:0] code;

  // bank index takes the address bits in reverse order
  for (genvar i = 0; i < BA_W; i++) begin : g_bank_map
    assign bank[i] = ba_i[BA_W-1-i];
  end

  ddr_cmd_decode u_dec (
    .cs_ni (cs_ni),
    .ras_ni(ras_ni),
    .cas_ni(cas_ni),
    .we_ni (we_ni),
    .cmd_o (cmd)
  );

  ddr_bank_state #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .BA_W(BA_W)) u_banks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .bank_i    (bank),
    .a10_i     (a10_i),
    .open_o    (open),
    .since_wr_o(bank_wr),
    .since_rd_o(bank_rd)
  );

  ddr_gap_timer #(.CNT_W(CNT_W)) u_wr_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cmd == CMD_WR), .cnt_o(since_wr));
  ddr_gap_timer #(.CNT_W(CNT_W)) u_rd_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cmd == CMD_RD), .cnt_o(since_rd));
  ddr_gap_timer #(.CNT_W(CNT_W)) u_bst_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cmd == CMD_BST), .cnt_o(since_bst));
  ddr_gap_timer #(.CNT_W(CNT_W)) u_mrs_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cmd == CMD_MRS), .cnt_o(since_mrs));

  ddr_rule_eval #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .BA_W(BA_W)) u_rules (
    .cmd_i      (cmd),
    .bank_i     (bank),
    .a10_i      (a10_i),
    .bl_sel_i   (bl_sel_i),
    .cl_half_i  (cl_half_i),
    .open_i     (open),
    .bank_wr_i  (bank_wr),
    .bank_rd_i  (bank_rd),
    .since_wr_i (since_wr),
    .since_rd_i (since_rd),
    .since_bst_i(since_bst),
    .since_mrs_i(since_mrs),
    .viol_o     (viol)
  );

  // lowest flagged rule index wins
  always_comb begin
    code = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (viol[i]) code = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_vld_o   <= 1'b0;
      cmd_o       <= 3'd0;
      viol_o      <= '0;
      viol_code_o <= '0;
    end else begin
      cmd_vld_o   <= (cmd != CMD_NOP);
      cmd_o       <= cmd;
      viol_o      <= viol;
      viol_code_o <= code;
    end
  end
endmodule

// File: rtl/ddr_cmd_checker_sva.sv
module ddr_cmd_checker_sva
  import ddr_chk_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cs_ni,
  input logic                 cmd_vld_o,
  input logic [2:0]           cmd_o,
  input logic [NUM_RULES-1:0] viol_o,
  input logic [CODE_W-1:0]    viol_code_o
);
  assert_desel_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!cmd_vld_o && viol_o == '0));

  assert_vld_not_nop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> (cmd_o != 3'd0));

  assert_flag_needs_cmd_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o != '0) |-> cmd_vld_o);

  assert_code_tracks_flags_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o == '0) == (viol_code_o == '0));

  assert_state_priority_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o[RULE_STATE] |-> (viol_code_o == CODE_W'(1)));

  assert_pre_rules_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o[RULE_WR2PRE] || viol_o[RULE_RD2PRE]) |-> (cmd_o == 3'd4));

  assert_wr2rd_on_rd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o[RULE_WR2RD] |-> (cmd_o == 3'd2));

  assert_wr_rules_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o[RULE_RD2WR] || viol_o[RULE_BST2WR]) |-> (cmd_o == 3'd3));

  assert_mrs_rule_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o[RULE_MRS] |-> (cmd_o == 3'd1 || cmd_o == 3'd6));
endmodule

bind ddr_cmd_checker ddr_cmd_checker_sva u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .cmd_vld_o  (cmd_vld_o),
  .cmd_o      (cmd_o),
  .viol_o     (viol_o),
  .viol_code_o(viol_code_o)
);

// File: tb/ddr_cmd_checker_bench.sv
module ddr_cmd_checker_bench;
  import ddr_chk_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0] ba, bl_sel;
  logic cl_half;
  logic cmd_vld;
  logic [2:0] cmd_out;
  logic [6:0] viol;
  logic [2:0] code;

  ddr_cmd_checker u_ddr_cmd_checker (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .ba_i(ba), .a10_i(a10), .bl_sel_i(bl_sel), .cl_half_i(cl_half),
    .cmd_vld_o(cmd_vld), .cmd_o(cmd_out), .viol_o(viol), .viol_code_o(code)
  );

  typedef struct packed {
    logic       vld;
    logic [2:0] cmd;
    logic [6:0] viol;
    logic [2:0] code;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_chk = 0;
  int n_fail = 0;

  // reference model: absolute cycle stamps
  int cyc = 0;
  bit open_m[4];
  int lw_b[4], lr_b[4];
  int lw = -100, lr = -100, lb = -100, lm = -100;
  logic [1:0] bl_cfg = 2'b01;
  logic cl_cfg = 1'b0;

  task automatic issue(input logic cs, input cmd_e c, input int b, input logic ap,
                       input string tag);
    exp_t e;
    int half;
    logic [2:0] pins;
    @(negedge clk);
    case (c)
      CMD_ACT: pins = 3'b011;
      CMD_RD:  pins = 3'b101;
      CMD_WR:  pins = 3'b100;
      CMD_PRE: pins = 3'b010;
      CMD_REF: pins = 3'b001;
      CMD_MRS: pins = 3'b000;
      CMD_BST: pins = 3'b110;
      default: pins = 3'b111;
    endcase
    cs_n = cs; {ras_n, cas_n, we_n} = pins;
    ba = {b[0], b[1]};
    a10 = ap; bl_sel = bl_cfg; cl_half = cl_cfg;
    half = (bl_cfg == 2'b00) ? 1 : (bl_cfg == 2'b01) ? 2 : 4;
    e = '0;
    if (!cs && c != CMD_NOP) begin
      e.vld = 1'b1;
      e.cmd = c;
      e.viol[0] = ((c == CMD_RD || c == CMD_WR) && !open_m[b]) || (c == CMD_ACT && open_m[b]);
      if (c == CMD_PRE) begin
        for (int k = 0; k < 4; k++) begin
          if (open_m[k] && (ap || k == b)) begin
            if (cyc - lw_b[k] < 3 + half) e.viol[1] = 1'b1;
            if (cyc - lr_b[k] < half)     e.viol[2] = 1'b1;
          end
        end
      end
      e.viol[3] = (c == CMD_RD) && (cyc - lw < 2 + half);
      e.viol[4] = (c == CMD_WR) && (cyc - lr < 2 + half + int'(cl_cfg));
      e.viol[5] = (c == CMD_WR) && (cyc - lb < 2 + int'(cl_cfg));
      e.viol[6] = (c == CMD_ACT || c == CMD_MRS) && (cyc - lm < 2);
      for (int i = 6; i >= 0; i--) if (e.viol[i]) e.code = 3'(i + 1);
      case (c)
        CMD_ACT: open_m[b] = 1'b1;
        CMD_PRE: if (ap) begin for (int k = 0; k < 4; k++) open_m[k] = 1'b0; end
                 else open_m[b] = 1'b0;
        CMD_RD:  begin lr = cyc; lr_b[b] = cyc; if (ap) open_m[b] = 1'b0; end
        CMD_WR:  begin lw = cyc; lw_b[b] = cyc; if (ap) open_m[b] = 1'b0; end
        CMD_BST: lb = cyc;
        CMD_MRS: lm = cyc;
        default: ;
      endcase
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    cyc++;
  endtask

  task automatic nop(input int n, input string tag);
    for (int i = 0; i < n; i++) issue(1'b0, CMD_NOP, 0, 1'b0, tag);
  endtask

  task automatic cmd(input cmd_e c, input int b, input string tag);
    issue(1'b0, c, b, 1'b0, tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if ({cmd_vld, cmd_out, viol, code} !== e) begin
          n_fail++;
          $display("FAIL %s: got vld=%0b cmd=%0d viol=%b code=%0d exp vld=%0b cmd=%0d viol=%b code=%0d",
                   t, cmd_vld, cmd_out, viol, code, e.vld, e.cmd, e.viol, e.code);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin open_m[k] = 0; lw_b[k] = -100; lr_b[k] = -100; end
    rst_n = 1'b0; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; ba = 0; a10 = 0;
    bl_sel = 2'b01; cl_half = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if ({cmd_vld, cmd_out, viol, code} !== '0) begin
      n_fail++;
      $display("FAIL R12 reset: got %b expected 0", {cmd_vld, cmd_out, viol, code});
    end
    @(negedge clk); rst_n = 1'b1;

    // R10 / R2 mode-register spacing
    cmd(CMD_MRS, 0, "R2");
    cmd(CMD_ACT, 0, "R10");
    nop(1, "R2");
    cmd(CMD_MRS, 0, "R10");
    nop(1, "R10");
    cmd(CMD_ACT, 1, "R10");
    cmd(CMD_MRS, 0, "R10");
    cmd(CMD_MRS, 0, "R10");
    nop(1, "R10");
    cmd(CMD_REF, 0, "R2");
    // R11 bank state
    cmd(CMD_ACT, 0, "R11");
    cmd(CMD_RD, 2, "R11");
    // R7 / R8 at CL2, BL4
    nop(4, "R8");
    cmd(CMD_RD, 0, "R8");
    cmd(CMD_WR, 0, "R8");
    nop(2, "R7");
    cmd(CMD_RD, 1, "R7");
    nop(3, "R8");
    cmd(CMD_WR, 1, "R8");
    nop(3, "R7");
    cmd(CMD_RD, 1, "R7");
    // R1 deselected cycles leave state alone
    nop(6, "R1");
    issue(1'b1, CMD_PRE, 0, 1'b1, "R1");
    issue(1'b1, CMD_MRS, 0, 1'b0, "R1");
    cmd(CMD_RD, 0, "R1");
    cmd(CMD_ACT, 3, "R1");
    // R5 / R6 precharge spacing
    nop(8, "R5");
    cmd(CMD_WR, 0, "R5");
    nop(3, "R5");
    cmd(CMD_PRE, 0, "R5");
    cmd(CMD_ACT, 0, "R5");
    cmd(CMD_WR, 0, "R5");
    nop(4, "R5");
    cmd(CMD_PRE, 0, "R5");
    cmd(CMD_ACT, 0, "R6");
    nop(4, "R6");
    cmd(CMD_RD, 0, "R6");
    cmd(CMD_PRE, 0, "R6");
    cmd(CMD_ACT, 0, "R6");
    cmd(CMD_RD, 0, "R6");
    nop(1, "R6");
    cmd(CMD_PRE, 0, "R6");
    // R3 all-bank and single-bank precharge
    nop(8, "R3");
    cmd(CMD_ACT, 0, "R3");
    nop(4, "R3");
    cmd(CMD_WR, 1, "R5");
    nop(1, "R5");
    issue(1'b0, CMD_PRE, 2, 1'b1, "R5");
    nop(8, "R3");
    cmd(CMD_RD, 0, "R3");
    cmd(CMD_RD, 1, "R3");
    cmd(CMD_RD, 3, "R3");
    nop(4, "R3");
    cmd(CMD_ACT, 0, "R3");
    cmd(CMD_ACT, 1, "R3");
    nop(6, "R3");
    cmd(CMD_PRE, 0, "R3");
    nop(1, "R3");
    cmd(CMD_RD, 1, "R3");
    cmd(CMD_RD, 0, "R3");
    // R4 auto-precharge
    nop(4, "R4");
    cmd(CMD_ACT, 2, "R4");
    nop(4, "R4");
    issue(1'b0, CMD_WR, 2, 1'b1, "R4");
    nop(8, "R4");
    cmd(CMD_RD, 2, "R4");
    nop(8, "R4");
    cmd(CMD_ACT, 2, "R4");
    // R13 burst length encodings
    bl_cfg = 2'b10;
    nop(8, "R13");
    cmd(CMD_WR, 2, "R13");
    nop(5, "R13");
    cmd(CMD_PRE, 2, "R13");
    cmd(CMD_ACT, 2, "R13");
    nop(8, "R13");
    cmd(CMD_WR, 2, "R13");
    nop(6, "R13");
    cmd(CMD_PRE, 2, "R13");
    bl_cfg = 2'b00;
    cmd(CMD_ACT, 2, "R13");
    nop(6, "R13");
    cmd(CMD_RD, 2, "R13");
    cmd(CMD_PRE, 2, "R13");
    bl_cfg = 2'b11;
    cmd(CMD_ACT, 2, "R13");
    nop(2, "R13");
    cmd(CMD_RD, 2, "R13");
    nop(2, "R13");
    cmd(CMD_PRE, 2, "R13");
    // R9 / R8 at CL2.5, BL4
    bl_cfg = 2'b01; cl_cfg = 1'b1;
    nop(10, "R9");
    cmd(CMD_ACT, 3, "R9");
    nop(2, "R9");
    cmd(CMD_BST, 0, "R9");
    cmd(CMD_WR, 3, "R9");
    nop(4, "R9");
    cmd(CMD_BST, 0, "R9");
    nop(2, "R9");
    cmd(CMD_WR, 3, "R9");
    nop(4, "R8");
    cmd(CMD_RD, 3, "R8");
    nop(3, "R8");
    cmd(CMD_WR, 3, "R8");
    nop(4, "R8");
    cmd(CMD_RD, 3, "R8");
    nop(4, "R8");
    cmd(CMD_WR, 3, "R8");
    cl_cfg = 1'b0;
    nop(8, "R9");
    cmd(CMD_BST, 0, "R9");
    nop(1, "R9");
    cmd(CMD_WR, 3, "R9");
    // R12 priority and command still applied
    nop(8, "R12");
    cmd(CMD_RD, 3, "R12");
    cmd(CMD_WR, 0, "R12");
    cmd(CMD_RD, 3, "R12");
    nop(3, "R12");

    wait (exp_q.size() == 0);
    @(posedge clk); #1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule